// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a memory reference into a 20-bit physical address using real-mode segmentation. It holds six 16-bit segment registers, and each can be written through a shared write port. For every request it picks a segment register and combines it with the offset. The segment is chosen from the access kind and the register that supplies the offset, unless an override names a segment directly.

The physical address is the chosen segment value shifted left by four bits plus the low 16 bits of the offset. The sum is taken modulo 2^20. The result, together with an exception flag, is registered and appears one cycle after the request. A request whose 32-bit offset exceeds 0xFFFF is illegal. For such a request the address output keeps its previous value and the exception flag pulses for one cycle.

Top module: `rm_addr_gen`

## Requirements
- R1: Each registered result is `(seg << 4) + offset[15:0]` modulo 2^20. It appears on `phys_addr` on the clock edge after the request with `req_valid` high.
- R2: For a fetch (`acc_kind` = 0), the code segment (select 0) is used and `ovr_valid` is ignored.
- R3: For a data access (`acc_kind` = 1) with no override, the segment is chosen from `base_id`. The stack segment (select 3) is used when `base_id` is 4 (stack pointer) or 5 (base pointer). Otherwise the data segment (select 1) is used; this covers the accumulator, base, count, data, source-index and destination-index registers (ids 0, 1, 2, 3, 6, 7) and a literal address (id 8).
- R4: For a string-destination access (`acc_kind` = 2) with no override, the extra segment (select 2) is used.
- R5: For a data or string-destination access with `ovr_valid` high, the segment named by `ovr_seg` is used. Segment selects are: 0 code, 1 data, 2 extra, 3 stack, 4 first additional, 5 second additional.
- R6: The two additional segments (selects 4 and 5) are never chosen by default. They are reached only through an override.
- R7: A request whose offset exceeds 0xFFFF raises `fault` for exactly one cycle, and `phys_addr` keeps its previous value.
- R8: A write to segment register `seg_wsel` with `seg_wr` high is used by any request presented on the following cycle or later.
- R9: After reset, `phys_addr` is 0, `fault` is 0 and all segment registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| acc_kind | input | 2 | 0 fetch, 1 data, 2 string destination |
| base_id | input | 4 | Register supplying the offset (0-7, 8 literal) |
| ovr_valid | input | 1 | Segment override present |
| ovr_seg | input | 3 | Override segment select |
| offset | input | 32 | Offset value |
| seg_wr | input | 1 | Segment register write enable |
| seg_wsel | input | 3 | Segment register write select |
| seg_wdata | input | 16 | Segment register write data |
| phys_addr | output | 20 | Registered physical address |
| fault | output | 1 | Illegal-offset pulse |

## Verification
On every cycle, the embedded assertions check four things:
- the fault is a single-cycle pulse;
- the address holds steady across a faulting request;
- the address holds steady when no request is made;
- the address matches the code segment plus offset for a legal fetch, even when an override is present.

Only the bench scenarios can show the rest:
- default segment choice for each base register;
- that the additional segments are reached only by override;
- wraparound at the top of the 1 MB space;
- write-then-use timing of the segment registers.

// File: rtl/rm_addr_gen.sv
module rm_addr_gen #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 32,
  parameter int ADDR_W = 20,
  parameter int NSEG   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        acc_kind,
  input  logic [3:0]        base_id,
  input  logic              ovr_valid,
  input  logic [2:0]        ovr_seg,
  input  logic [OFF_W-1:0]  offset,
  input  logic              seg_wr,
  input  logic [2:0]        seg_wsel,
  input  logic [SEG_W-1:0]  seg_wdata,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              fault
);
  localparam int SHIFT = ADDR_W - SEG_W;

  logic [SEG_W-1:0] segs [NSEG];
  logic [2:0]       dflt_sel, use_sel;
  logic             bad_off;
  logic [ADDR_W-1:0] sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) segs[i] <= '0;
    end else if (seg_wr && int'(seg_wsel) < NSEG) begin
      segs[seg_wsel] <= seg_wdata;
    end
  end

  always_comb begin
    case (acc_kind)
      2'd0:    dflt_sel = 3'd0;
      2'd2:    dflt_sel = 3'd2;
      default: dflt_sel = (base_id == 4'd4 || base_id == 4'd5) ? 3'd3 : 3'd1;
    endcase
  end

  assign use_sel = (acc_kind != 2'd0 && ovr_valid && int'(ovr_seg) < NSEG) ? ovr_seg : dflt_sel;
  assign bad_off = |offset[OFF_W-1:16];
  assign sum = {segs[use_sel], {SHIFT{1'b0}}} + {{(ADDR_W-16){1'b0}}, offset[15:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phys_addr <= '0;
      fault     <= 1'b0;
    end else begin
      fault <= req_valid && bad_off;
      if (req_valid && !bad_off) phys_addr <= sum;
    end
  end

  // R7
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault || $past(req_valid && bad_off));
  // R7
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bad_off) |=> $stable(phys_addr) && fault);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(phys_addr) && !fault);
  // R2
  fetch_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bad_off && acc_kind == 2'd0 && !seg_wr) |=>
      phys_addr == ADDR_W'({$past(segs[0]), {SHIFT{1'b0}}} + {{(ADDR_W-16){1'b0}}, $past(offset[15:0])}));
endmodule

// File: tb/test_rm_addr_gen.sv
module test_rm_addr_gen;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, ovr_valid = 0, seg_wr = 0;
  logic [1:0] acc_kind = 0;
  logic [3:0] base_id = 0;
  logic [2:0] ovr_seg = 0, seg_wsel = 0;
  logic [31:0] offset = 0;
  logic [15:0] seg_wdata = 0;
  logic [19:0] phys_addr;
  logic fault;
  int checks = 0, errors = 0;
  logic [15:0] model [6];
  logic [19:0] last_addr;

  always #5 clk = ~clk;

  rm_addr_gen i_rm_addr_gen (.clk, .rst_n, .req_valid, .acc_kind, .base_id,
    .ovr_valid, .ovr_seg, .offset, .seg_wr, .seg_wsel, .seg_wdata, .phys_addr, .fault);

  function automatic int pick(input logic [1:0] k, input logic [3:0] b,
                              input logic ov, input logic [2:0] os);
    if (k == 0) return 0;
    if (ov) return int'(os);
    if (k == 2) return 2;
    return (b == 4 || b == 5) ? 3 : 1;
  endfunction

  function automatic logic [19:0] calc(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wseg(input int s, input logic [15:0] v);
    @(negedge clk);
    seg_wr = 1; seg_wsel = 3'(s); seg_wdata = v;
    @(negedge clk);
    seg_wr = 0;
    model[s] = v;
  endtask

  task automatic access(input string r, input logic [1:0] k, input logic [3:0] b,
                        input logic ov, input logic [2:0] os, input logic [31:0] off);
    logic [19:0] e;
    logic bad;
    @(negedge clk);
    req_valid = 1; acc_kind = k; base_id = b; ovr_valid = ov; ovr_seg = os; offset = off;
    bad = |off[31:16];
    e = bad ? last_addr : calc(model[pick(k, b, ov, os)], off[15:0]);
    @(negedge clk);
    req_valid = 0;
    chk(r, {12'h0, phys_addr}, {12'h0, e});
    chk(r, {31'h0, fault}, {31'h0, bad});
    last_addr = e;
    if (bad) begin
      @(negedge clk);
      chk("R7", {31'h0, fault}, 32'h0);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 6; i++) model[i] = 0;
    last_addr = 0;
    repeat (3) @(negedge clk);
    chk("R9", {12'h0, phys_addr}, 32'h0);
    chk("R9", {31'h0, fault}, 32'h0);
    rst_n = 1;
    access("R9", 1, 6, 0, 0, 32'h1234);
    wseg(0, 16'h1000); wseg(1, 16'h2000); wseg(2, 16'h3400);
    wseg(3, 16'h4900); wseg(4, 16'h5000); wseg(5, 16'h6000);
    access("R1", 1, 1, 0, 0, 32'h0000F000);
    access("R2", 0, 0, 1, 3, 32'h0010);
    for (int b = 0; b < 9; b++) access("R3", 1, 4'(b), 0, 0, 32'h0100);
    access("R4", 2, 7, 0, 0, 32'h0020);
    access("R5", 1, 4, 1, 2, 32'h0030);
    access("R6", 1, 8, 1, 4, 32'h0040);
    access("R6", 2, 7, 1, 5, 32'h0050);
    wseg(1, 16'hFFFF);
    access("R1", 1, 3, 0, 0, 32'h0000FFFF);
    access("R7", 1, 1, 0, 0, 32'h00010000);
    access("R7", 0, 0, 0, 0, 32'hFFFFFFFF);
    @(negedge clk);
    seg_wr = 1; seg_wsel = 3; seg_wdata = 16'h0ABC;
    @(negedge clk);
    seg_wr = 0; model[3] = 16'h0ABC;
    access("R8", 1, 5, 0, 0, 32'h0004);
    for (int n = 0; n < 300; n++) begin
      logic [1:0] k;
      logic [31:0] off;
      if ($urandom % 5 == 0) wseg(int'($urandom % 6), 16'($urandom));
      k = 2'($urandom % 3);
      off = ($urandom % 8 == 0) ? $urandom : {16'h0, 16'($urandom)};
      access("R5", k, 4'($urandom % 9), 1'($urandom), 3'($urandom % 6), off);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule